// File: doc/BRIEF.md
# Single-Wire Register Access Initiator

This block is the initiating end of a half-duplex, one-wire register link. A client hands it a read or write request through a valid/ready command port: an opcode bit, a 5-bit register address, a byte of write data and the length of one bit on the wire, counted in clock cycles. The block then plays out the whole frame on the shared line. It drives the preamble, the opcode, the address and, on a write, the data and check bits. It lets go of the line at every turnaround point. It samples whatever the target sends back and reports the outcome as a single response pulse that carries the read byte and an error flag.

Between frames the line belongs to the target, which may pull it to the active level for a few cycles to raise an interrupt. The block watches for such a pulse only while it holds no frame in flight, and turns each one into a one-cycle flag. The active level is chosen by a polarity input. That input also decides the preamble pattern.

Top module: `swire_host`

## Requirements
- R1: With `irq_active_high` = 0 the first three bits of a frame are 1,0,1, and with `irq_active_high` = 1 they are 0,1,0. All three are driven (`line_oe` = 1). Whenever no frame is in flight, `line_oe` is 0.
- R2: After the preamble the block drives the opcode (1,1,0 for a read with `cmd_write` = 0, 0,1,1 for a write), then the five address bits, most significant first. Every bit on the wire lasts exactly the latched period in cycles.
- R3: Bit 11 of each frame (counting from 0) is a turnaround bit with `line_oe` = 0. Bits 12 to 19 carry the data byte, most significant first. A write drives them; a read releases the line and samples each bit at cycle period/2 (rounded down) of that bit.
- R4: Bits 20 and 21 form a check pair. The first bit is 1 exactly when the opcode, address and data bits together hold an odd number of ones, and the second bit is its complement. A write drives the pair.
- R5: After bit 21 a write releases the line for one bit, then samples two acknowledge bits (bits 23 and 24). `rsp_error` is 1 exactly when those two bits differ from the check pair that was sent.
- R6: A read returns the eight sampled data bits on `rsp_rdata`. `rsp_error` is 1 exactly when the two received check bits differ from the pair computed over the opcode, the address and the received data.
- R7: Every frame ends with two released bits. A read frame is 24 bits long and a write frame 27 bits. `cmd_ready` is 0 from the first preamble bit through the last trailing bit. `rsp_valid` is high for one cycle, the cycle right after the last trailing bit, and `cmd_ready` is 1 again in that cycle.
- R8: The requested period is clamped into the range 4 to 1024 cycles when the command is accepted. Requests below 4 run at 4, and requests above 1024 run at 1024.
- R9: While no frame is in flight, the line held at the active level (low when `irq_active_high` = 0, high when it is 1) for four consecutive cycles makes `irq_pulse` high for one cycle, in the cycle after the fourth. A longer hold gives only one pulse, a shorter hold gives none, and line activity during a frame gives none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Request present |
| cmd_ready | output | 1 | Block is free to accept a request |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | 5 | Register address |
| cmd_wdata | input | 8 | Write data |
| cmd_period | input | 11 | Requested bit length in clock cycles |
| irq_active_high | input | 1 | Active level of the line: 1 = high, 0 = low |
| line_in | input | 1 | Sensed level of the shared wire |
| line_out | output | 1 | Level driven onto the wire when enabled |
| line_oe | output | 1 | Drive enable for the wire |
| rsp_valid | output | 1 | One-cycle completion strobe |
| rsp_rdata | output | 8 | Read data (0 after a write) |
| rsp_error | output | 1 | Check-pair or acknowledge mismatch |
| irq_pulse | output | 1 | One-cycle interrupt indication |

## Verification
With the request accepted on clock edge A, bit i of a frame covers the P cycles that start right after edge A + i·P. The bench steps through every cycle at the falling edge. It checks drive enable and driven level one cycle into each bit, and changes its own line level at the start of each bit so that it is steady when the block samples at mid-bit. The response is due exactly frame-length × P cycles after acceptance, and the bench reads it at that falling edge. An interrupt flag is due one cycle after the fourth active-level cycle, and the bench records the cycle in which each flag appears, so a flag that comes early, late or twice counts as a failure.

// File: rtl/swire_pkg.sv
package swire_pkg;

    // fixed field sizes of the frame
    localparam int ADDR_W     = 5;
    localparam int DATA_W     = 8;
    localparam int PRE_BITS   = 3;
    localparam int OP_BITS    = 3;
    localparam int CHK_BITS   = 2;
    localparam int ACK_BITS   = 2;
    localparam int TAIL_BITS  = 2;

    // derived bit positions inside a frame
    localparam int HDR_BITS   = PRE_BITS + OP_BITS + ADDR_W;          // 11
    localparam int TURN_IDX   = HDR_BITS;                             // 11
    localparam int DATA_FIRST = HDR_BITS + 1;                         // 12
    localparam int TX_BITS    = DATA_FIRST + DATA_W + CHK_BITS;       // 22
    localparam int RD_LEN     = TX_BITS + TAIL_BITS;                  // 24
    localparam int WR_LEN     = TX_BITS + 1 + ACK_BITS + TAIL_BITS;   // 27
    localparam int IDX_W      = $clog2(WR_LEN);
    localparam int RX_W       = DATA_W + CHK_BITS;

    localparam logic [OP_BITS-1:0]  OP_RD  = 3'b110;
    localparam logic [OP_BITS-1:0]  OP_WR  = 3'b011;
    localparam logic [PRE_BITS-1:0] PRE_LO = 3'b101;
    localparam logic [PRE_BITS-1:0] PRE_HI = 3'b010;

    typedef enum logic [1:0] {
        ROLE_DRIVE   = 2'd0,
        ROLE_RELEASE = 2'd1,
        ROLE_SAMPLE  = 2'd2
    } role_e;

    // what the initiator does with the wire during bit idx
    function automatic role_e bit_role(input logic is_wr, input logic [IDX_W-1:0] idx);
        int i;
        i = int'(idx);
        if (i < HDR_BITS)                               return ROLE_DRIVE;
        if (i == TURN_IDX)                              return ROLE_RELEASE;
        if (i < TX_BITS)                                return is_wr ? ROLE_DRIVE : ROLE_SAMPLE;
        if (is_wr && (i == TX_BITS))                    return ROLE_RELEASE;
        if (is_wr && (i < TX_BITS + 1 + ACK_BITS))      return ROLE_SAMPLE;
        return ROLE_RELEASE;
    endfunction

endpackage

// File: rtl/swire_bit_timer.sv
module swire_bit_timer #(
    parameter int PER_W   = 11,
    parameter int PER_MIN = 4,
    parameter int PER_MAX = 1024
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [PER_W-1:0] period_in,
    input  logic             run,
    output logic             bit_end,
    output logic             sample_now
);

    localparam logic [PER_W-1:0] MIN_V = PER_W'(PER_MIN);
    localparam logic [PER_W-1:0] MAX_V = PER_W'(PER_MAX);

    typedef struct packed {
        logic [PER_W-1:0] cnt;
        logic [PER_W-1:0] per;
    } tmr_t;

    tmr_t q, d;

    assign bit_end    = run && (q.cnt == q.per - 1'b1);
    assign sample_now = run && (q.cnt == (q.per >> 1));

    always_comb begin
        d = q;
        if (load) begin
            d.cnt = '0;
            if (period_in < MIN_V)      d.per = MIN_V;
            else if (period_in > MAX_V) d.per = MAX_V;
            else                        d.per = period_in;
        end else if (run) begin
            d.cnt = bit_end ? '0 : q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{cnt: '0, per: MIN_V};
        else        q <= d;
    end

    assert_period_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.per >= MIN_V) && (q.per <= MAX_V));

    assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt < q.per);

    assert_cnt_wraps_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_end && !load) |=> (q.cnt == '0));

endmodule

// File: rtl/swire_frame_seq.sv
module swire_frame_seq
    import swire_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_write,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_wdata,
    input  logic              irq_active_high,
    input  logic              line_in,
    input  logic              bit_end,
    input  logic              sample_now,
    output logic              cmd_ready,
    output logic              load,
    output logic              busy,
    output logic              line_out,
    output logic              line_oe,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_error
);

    typedef struct packed {
        logic               busy;
        logic               is_wr;
        logic [IDX_W-1:0]   idx;
        logic [TX_BITS-1:0] tx;
        logic [RX_W-1:0]    rx;
        logic               rsp_valid;
        logic [DATA_W-1:0]  rdata;
        logic               err;
    } seq_t;

    seq_t q, d;

    role_e              role;
    logic [TX_BITS-1:0] tx_shift;
    logic [IDX_W-1:0]   last_idx;
    logic               accept;
    logic               chk_bit;
    logic               rx_chk;

    assign role      = bit_role(q.is_wr, q.idx);
    assign tx_shift  = q.tx << q.idx;
    assign last_idx  = q.is_wr ? IDX_W'(WR_LEN - 1) : IDX_W'(RD_LEN - 1);
    assign accept    = cmd_valid && !q.busy;

    assign cmd_ready = !q.busy;
    assign load      = accept;
    assign busy      = q.busy;
    assign line_oe   = q.busy && (role == ROLE_DRIVE);
    assign line_out  = line_oe ? tx_shift[TX_BITS-1] : 1'b0;
    assign rsp_valid = q.rsp_valid;
    assign rsp_rdata = q.rdata;
    assign rsp_error = q.err;

    always_comb begin
        d           = q;
        d.rsp_valid = 1'b0;
        chk_bit     = 1'b0;
        rx_chk      = 1'b0;
        if (accept) begin
            d.busy  = 1'b1;
            d.is_wr = cmd_write;
            d.idx   = '0;
            d.rx    = '0;
            chk_bit = ^{(cmd_write ? OP_WR : OP_RD), cmd_addr, (cmd_write ? cmd_wdata : '0)};
            d.tx    = {(irq_active_high ? PRE_HI : PRE_LO),
                       (cmd_write ? OP_WR : OP_RD),
                       cmd_addr,
                       1'b0,
                       (cmd_write ? cmd_wdata : '0),
                       chk_bit, ~chk_bit};
        end else if (q.busy) begin
            if (sample_now && (role == ROLE_SAMPLE))
                d.rx = {q.rx[RX_W-2:0], line_in};
            if (bit_end) begin
                if (q.idx == last_idx) begin
                    d.busy      = 1'b0;
                    d.rsp_valid = 1'b1;
                    if (q.is_wr) begin
                        d.rdata = '0;
                        d.err   = (d.rx[CHK_BITS-1:0] != q.tx[CHK_BITS-1:0]);
                    end else begin
                        rx_chk  = ^{q.tx[TX_BITS-PRE_BITS-1 -: OP_BITS+ADDR_W],
                                    d.rx[RX_W-1 -: DATA_W]};
                        d.rdata = d.rx[RX_W-1 -: DATA_W];
                        d.err   = (d.rx[CHK_BITS-1:0] != {rx_chk, ~rx_chk});
                    end
                end else begin
                    d.idx = q.idx + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assert_first_bit_driven_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.busy) |-> line_oe);

    assert_rsp_when_free_R7: assert property (@(posedge clk) disable iff (!rst_n)
        q.rsp_valid |-> cmd_ready);

    assert_rsp_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        q.rsp_valid |=> !q.rsp_valid);

    assert_rsp_after_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.busy) |-> q.rsp_valid);

endmodule

// File: rtl/swire_irq_detect.sv
module swire_irq_detect #(
    parameter int HOLD = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic idle,
    input  logic active_high,
    input  logic line_in,
    output logic irq_pulse
);

    localparam int CW = $clog2(HOLD + 1);
    localparam logic [CW-1:0] HOLD_V = CW'(HOLD);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          irq;
    } irq_t;

    irq_t q, d;
    logic at_active;

    assign at_active = (line_in == active_high);
    assign irq_pulse = q.irq;

    always_comb begin
        d     = q;
        d.irq = 1'b0;
        if (idle && at_active) begin
            if (q.cnt < HOLD_V) d.cnt = q.cnt + 1'b1;
            d.irq = (q.cnt == HOLD_V - 1'b1);
        end else begin
            d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assert_irq_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        q.irq |=> !q.irq);

    assert_irq_only_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        q.irq |-> $past(idle));

endmodule

// File: rtl/swire_host.sv
module swire_host
    import swire_pkg::*;
#(
    parameter int PER_W    = 11,
    parameter int PER_MIN  = 4,
    parameter int PER_MAX  = 1024,
    parameter int IRQ_HOLD = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic              cmd_write,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_wdata,
    input  logic [PER_W-1:0]  cmd_period,
    input  logic              irq_active_high,
    input  logic              line_in,
    output logic              line_out,
    output logic              line_oe,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_error,
    output logic              irq_pulse
);

    logic load, busy, bit_end, sample_now;

    swire_bit_timer #(
        .PER_W  (PER_W),
        .PER_MIN(PER_MIN),
        .PER_MAX(PER_MAX)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .period_in (cmd_period),
        .run       (busy),
        .bit_end   (bit_end),
        .sample_now(sample_now)
    );

    swire_frame_seq u_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .cmd_valid      (cmd_valid),
        .cmd_write      (cmd_write),
        .cmd_addr       (cmd_addr),
        .cmd_wdata      (cmd_wdata),
        .irq_active_high(irq_active_high),
        .line_in        (line_in),
        .bit_end        (bit_end),
        .sample_now     (sample_now),
        .cmd_ready      (cmd_ready),
        .load           (load),
        .busy           (busy),
        .line_out       (line_out),
        .line_oe        (line_oe),
        .rsp_valid      (rsp_valid),
        .rsp_rdata      (rsp_rdata),
        .rsp_error      (rsp_error)
    );

    swire_irq_detect #(
        .HOLD(IRQ_HOLD)
    ) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .idle       (!busy),
        .active_high(irq_active_high),
        .line_in    (line_in),
        .irq_pulse  (irq_pulse)
    );

    assert_idle_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> !line_oe);

    assert_accept_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> !cmd_ready);

endmodule

// File: tb/swire_host_test.sv
`timescale 1ns/1ps
module swire_host_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic        cmd_write = 1'b0;
    logic [4:0]  cmd_addr = '0;
    logic [7:0]  cmd_wdata = '0;
    logic [10:0] cmd_period = 11'd4;
    logic        irq_active_high = 1'b0;
    logic        line_in;
    logic        line_out, line_oe;
    logic        rsp_valid, rsp_error, irq_pulse;
    logic [7:0]  rsp_rdata;
    logic        tb_drv = 1'b1;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    assign line_in = line_oe ? line_out : tb_drv;

    swire_host uut (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_period(cmd_period),
        .irq_active_high(irq_active_high), .line_in(line_in),
        .line_out(line_out), .line_oe(line_oe),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_error(rsp_error),
        .irq_pulse(irq_pulse)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one complete frame against a bench-modelled target
    task automatic run_frame(input bit wr, input logic [4:0] a, input logic [7:0] dat,
                             input int per_req, input bit pol, input bit bad, input string tag);
        int p, nb, drv_err, oe_err, rdy_err, irq_cnt, first_bad;
        logic [21:0] exp_tx;
        logic [2:0]  op;
        logic        par;
        logic [1:0]  reply_pair;
        p  = (per_req < 4) ? 4 : ((per_req > 1024) ? 1024 : per_req);   // R8
        nb = wr ? 27 : 24;                                                // R7
        op = wr ? 3'b011 : 3'b110;                                        // R2
        par = ^{op, a, dat};                                              // R4
        exp_tx = {(pol ? 3'b010 : 3'b101), op, a, 1'b0, dat, par, ~par};  // R1 R2 R3
        reply_pair = bad ? {~par, par} : {par, ~par};                     // R5 R6
        drv_err = 0; oe_err = 0; rdy_err = 0; irq_cnt = 0; first_bad = -1;

        irq_active_high = pol;
        tb_drv = ~pol;
        cmd_write = wr; cmd_addr = a; cmd_wdata = dat; cmd_period = 11'(per_req);
        cmd_valid = 1'b1;
        chk(cmd_ready == 1'b1, {"R7 ready before frame ", tag}, cmd_ready, 1);
        @(posedge clk); @(negedge clk);
        cmd_valid = 1'b0;

        for (int i = 0; i < nb; i++) begin
            bit exp_oe;
            exp_oe = (i < 11) || (wr && (i >= 12) && (i < 22));
            for (int c = 0; c < p; c++) begin
                if (c == 0) begin
                    if (!wr && i >= 12 && i < 20)      tb_drv = dat[19 - i];
                    else if (!wr && i >= 20 && i < 22) tb_drv = reply_pair[21 - i];
                    else if (wr && i >= 23 && i < 25)  tb_drv = reply_pair[24 - i];
                    else                               tb_drv = ~pol;
                end
                if (c == 1) begin
                    if (line_oe != exp_oe) begin
                        oe_err++;
                        if (first_bad < 0) first_bad = i;
                    end
                    if (exp_oe && line_out != exp_tx[21 - i]) begin
                        drv_err++;
                        if (first_bad < 0) first_bad = i;
                    end
                end
                if (cmd_ready != 1'b0) rdy_err++;
                if (irq_pulse) irq_cnt++;
                @(posedge clk); @(negedge clk);
            end
        end
        tb_drv = ~pol;

        chk(drv_err == 0, {"R1 R2 R4 R8 driven bits ", tag}, first_bad, -1);
        chk(oe_err == 0, {"R3 R5 R7 drive enable ", tag}, first_bad, -1);
        chk(rdy_err == 0, {"R7 busy during frame ", tag}, rdy_err, 0);
        chk(irq_cnt == 0, {"R9 no irq during frame ", tag}, irq_cnt, 0);
        chk(rsp_valid == 1'b1 && cmd_ready == 1'b1, {"R7 response timing ", tag},
            {rsp_valid, cmd_ready}, 3);
        chk(rsp_error == bad, {(wr ? "R5 ack check " : "R6 read check "), tag}, rsp_error, bad);
        if (!wr) chk(rsp_rdata == dat, {"R3 R6 read data ", tag}, rsp_rdata, dat);
        @(negedge clk);
        chk(rsp_valid == 1'b0, {"R7 response one cycle ", tag}, rsp_valid, 0);
    endtask

    // idle line held active for n cycles; pulse due in cycle 4 when n >= 4
    task automatic irq_probe(input int n, input bit pol);
        int seen, at;
        irq_active_high = pol;
        tb_drv = ~pol;
        repeat (3) @(negedge clk);
        seen = 0; at = -1;
        for (int c = 0; c < n + 6; c++) begin
            tb_drv = (c < n) ? pol : ~pol;
            if (irq_pulse) begin
                seen++;
                if (at < 0) at = c;
            end
            @(negedge clk);
        end
        tb_drv = ~pol;
        if (n >= 4) chk(seen == 1 && at == 4, "R9 irq pulse", seen * 100 + at, 104);
        else        chk(seen == 0, "R9 short pulse ignored", seen, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cmd_ready == 1'b1, "R7 reset ready", cmd_ready, 1);
        chk(line_oe == 1'b0, "R1 reset released", line_oe, 0);
        chk(rsp_valid == 1'b0 && irq_pulse == 1'b0, "R9 reset quiet", {rsp_valid, irq_pulse}, 0);

        for (int pi = 0; pi < 3; pi++)
            for (int pol = 0; pol < 2; pol++)
                for (int wr = 0; wr < 2; wr++)
                    for (int di = 0; di < 4; di++)
                        run_frame(wr[0], 5'(di * 7 + pi * 3 + pol), 8'(di * 8'h5B + pol * 8'h21 + pi),
                                  (pi == 2) ? 7 : 4 + pi, pol[0], di == 3, "sweep");

        run_frame(1'b1, 5'h1F, 8'hFF, 1, 1'b0, 1'b0, "R8 clamp low");
        run_frame(1'b0, 5'h00, 8'h00, 3, 1'b0, 1'b0, "R8 clamp low read");
        run_frame(1'b0, 5'h15, 8'h81, 1500, 1'b1, 1'b0, "R8 clamp high");

        for (int pol = 0; pol < 2; pol++) begin
            irq_probe(3, pol[0]);
            irq_probe(4, pol[0]);
            irq_probe(6, pol[0]);
            irq_probe(10, pol[0]);
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule